// File: doc/BRIEF.md
# Coalescing EOI Tracker

This block follows a single periodic timer interrupt line. For that line it records which destination processors were handed the most recent delivery and have not yet returned an end-of-interrupt (EOI). Whenever any acknowledgement is still outstanding, the line counts as busy. A fresh assertion of the line during that time is refused and reported as coalesced, even though the line itself is edge-triggered. Software that manages time uses this to see lost ticks, because coalesced timer interrupts make the guest clock drift.

The surrounding interrupt controller reports four kinds of event. A delivery-complete event carries a bitmap of the destinations that took the interrupt. An EOI event carries one destination index. A restore event sets or clears one destination's pending state while saved state is being reloaded. A clear event empties the tracker before a full restore. The block keeps a bitmap of pending destinations and a running count of the set bits. It reports whether it is busy, whether an incoming assertion is coalesced, and two error conditions. Delivery itself and the matching of destinations are handled outside the block.

Top module: `eoi_tracker`

## Requirements
- R1: `coalesced_o` is 1 exactly when `assert_i` is 1 and the outstanding count is non-zero. It is a combinational function of the current count.
- R2: A delivery-complete event (`dlv_done_i`) loads the pending bitmap with `dlv_mask_i` (bit k = destination k). It sets the count to the number of set bits in that mask. Both values are visible on the cycle after the event.
- R3: `err_start_o` is 1 exactly when `dlv_done_i` is 1 while the count is non-zero. The delivery is still applied and replaces the previous state.
- R4: An EOI (`eoi_valid_i`, index `eoi_dest_i`) for a destination whose bit is set clears that bit and lowers the count by one. An EOI for a destination whose bit is clear changes nothing.
- R5: Asserting `rst_ni` low, or `clear_i` high for one clock, empties the bitmap and sets the count to zero. `clear_i` takes priority over every other event in the same cycle.
- R6: A restore event (`sync_valid_i`, index `sync_dest_i`, state `sync_pend_i`) makes the destination's bit equal to `sync_pend_i`. The count rises by one when a bit is set, falls by one when a bit is cleared, and stays the same when the bit already had that value.
- R7: The count always equals the number of set bits in the bitmap. The underflow flag `err_under_o`, which would show a decrement at zero, therefore stays 0.
- R8: Events in the same cycle are applied in this order: delivery, then EOI, then restore. An EOI in the same cycle as a delivery acts on the bitmap that was just delivered.
- R9: `busy_o` is 1 exactly when the count is non-zero. The count is wide enough to hold `N_DEST` (default 16), including the case where all destinations are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Synchronous clear of tracking state |
| assert_i | input | 1 | New assertion of the tracked line |
| dlv_done_i | input | 1 | Delivery completed this cycle |
| dlv_mask_i | input | N_DEST | Destinations that accepted the delivery |
| eoi_valid_i | input | 1 | EOI event |
| eoi_dest_i | input | IDX_W | Destination issuing the EOI |
| sync_valid_i | input | 1 | Restore event |
| sync_dest_i | input | IDX_W | Destination being restored |
| sync_pend_i | input | 1 | Pending state reported for that destination |
| pend_map_o | output | N_DEST | Pending-acknowledgement bitmap |
| pend_cnt_o | output | CNT_W | Outstanding acknowledgement count |
| busy_o | output | 1 | Count is non-zero |
| coalesced_o | output | 1 | Current assertion refused |
| err_start_o | output | 1 | Delivery completed while busy |
| err_under_o | output | 1 | Decrement attempted at zero |

## Verification
The assertions check several rules on every cycle. The count must match the population of the bitmap. The coalesced output must agree with the count. A clear must leave the block empty. A lone delivery must load its mask exactly, and a stray EOI must leave the bitmap untouched. Underflow must never be flagged. Other behaviour is shown only by the bench scenarios. These cover the ordering of events in the same cycle, idempotent restores, and a delivery arriving while the block is busy. They also cover the all-destinations boundary and the return to empty after asynchronous reset in the middle of traffic.

// File: rtl/eoi_trk_pkg.sv
package eoi_trk_pkg;
  localparam int unsigned DEF_DESTS = 16;

  typedef enum logic [1:0] {
    SYNC_NONE = 2'd0,
    SYNC_SET  = 2'd1,
    SYNC_CLR  = 2'd2
  } sync_act_e;
endpackage

// File: rtl/eoi_trk_dec.sv
module eoi_trk_dec #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [N-1:0]     oh_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    assign oh_o[g] = en_i && (idx_i == IDX_W'(g));
  end
endmodule

// File: rtl/eoi_trk_popcnt.sv
module eoi_trk_popcnt #(
  parameter int unsigned N     = 16,
  parameter int unsigned CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + CNT_W'(vec_i[i]);
  end
endmodule

// File: rtl/eoi_tracker.sv
module eoi_tracker
  import eoi_trk_pkg::*;
#(
  parameter int unsigned N_DEST = DEF_DESTS,
  parameter int unsigned IDX_W  = (N_DEST > 1) ? $clog2(N_DEST) : 1,
  parameter int unsigned CNT_W  = $clog2(N_DEST + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              assert_i,
  input  logic              dlv_done_i,
  input  logic [N_DEST-1:0] dlv_mask_i,
  input  logic              eoi_valid_i,
  input  logic [IDX_W-1:0]  eoi_dest_i,
  input  logic              sync_valid_i,
  input  logic [IDX_W-1:0]  sync_dest_i,
  input  logic              sync_pend_i,
  output logic [N_DEST-1:0] pend_map_o,
  output logic [CNT_W-1:0]  pend_cnt_o,
  output logic              busy_o,
  output logic              coalesced_o,
  output logic              err_start_o,
  output logic              err_under_o
);
  logic [N_DEST-1:0] map_q, map_d, map_a, map_b;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_a, cnt_b, dlv_cnt;
  logic [N_DEST-1:0] eoi_oh, sync_oh;
  logic              eoi_hit, sync_old, under_eoi, under_sync;
  sync_act_e         sync_act;

  eoi_trk_popcnt #(.N(N_DEST), .CNT_W(CNT_W)) u_pop (
    .vec_i (dlv_mask_i),
    .cnt_o (dlv_cnt)
  );

  eoi_trk_dec #(.N(N_DEST), .IDX_W(IDX_W)) u_eoi_dec (
    .en_i  (eoi_valid_i),
    .idx_i (eoi_dest_i),
    .oh_o  (eoi_oh)
  );

  eoi_trk_dec #(.N(N_DEST), .IDX_W(IDX_W)) u_sync_dec (
    .en_i  (sync_valid_i),
    .idx_i (sync_dest_i),
    .oh_o  (sync_oh)
  );

  // stage a: delivery replaces state
  always_comb begin
    map_a = dlv_done_i ? dlv_mask_i : map_q;
    cnt_a = dlv_done_i ? dlv_cnt    : cnt_q;
  end

  // stage b: EOI acts on post-delivery map
  always_comb begin
    eoi_hit   = |(map_a & eoi_oh);
    under_eoi = eoi_hit && (cnt_a == '0);
    map_b     = map_a & ~(eoi_hit ? eoi_oh : '0);
    cnt_b     = cnt_a;
    if (eoi_hit && !under_eoi) cnt_b = cnt_a - CNT_W'(1);
  end

  // stage c: restore
  always_comb begin
    sync_old = |(map_b & sync_oh);
    sync_act = SYNC_NONE;
    if (sync_valid_i) begin
      if (sync_pend_i && !sync_old)      sync_act = SYNC_SET;
      else if (!sync_pend_i && sync_old) sync_act = SYNC_CLR;
    end
    under_sync = (sync_act == SYNC_CLR) && (cnt_b == '0);
    map_d = map_b;
    cnt_d = cnt_b;
    unique case (sync_act)
      SYNC_SET: begin
        map_d = map_b | sync_oh;
        cnt_d = cnt_b + CNT_W'(1);
      end
      SYNC_CLR: begin
        map_d = map_b & ~sync_oh;
        if (!under_sync) cnt_d = cnt_b - CNT_W'(1);
      end
      default: ;
    endcase
    if (clear_i) begin
      map_d = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q <= '0;
      cnt_q <= '0;
    end else begin
      map_q <= map_d;
      cnt_q <= cnt_d;
    end
  end

  assign pend_map_o  = map_q;
  assign pend_cnt_o  = cnt_q;
  assign busy_o      = (cnt_q != '0);
  assign coalesced_o = assert_i && busy_o;
  assign err_start_o = dlv_done_i && busy_o;
  assign err_under_o = !clear_i && (under_eoi || under_sync);
endmodule

// File: rtl/eoi_tracker_chk.sv
module eoi_tracker_chk #(
  parameter int unsigned N_DEST = 16,
  parameter int unsigned IDX_W  = (N_DEST > 1) ? $clog2(N_DEST) : 1,
  parameter int unsigned CNT_W  = $clog2(N_DEST + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              assert_i,
  input logic              dlv_done_i,
  input logic [N_DEST-1:0] dlv_mask_i,
  input logic              eoi_valid_i,
  input logic [IDX_W-1:0]  eoi_dest_i,
  input logic              sync_valid_i,
  input logic [IDX_W-1:0]  sync_dest_i,
  input logic              sync_pend_i,
  input logic [N_DEST-1:0] pend_map_o,
  input logic [CNT_W-1:0]  pend_cnt_o,
  input logic              busy_o,
  input logic              coalesced_o,
  input logic              err_start_o,
  input logic              err_under_o
);
  a_r7_cnt_matches_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(pend_cnt_o) == $countones(pend_map_o));

  a_r7_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_under_o);

  a_r1_coalesce_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (assert_i && pend_map_o != '0) |-> coalesced_o);

  a_r1_no_coalesce_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_map_o == '0) |-> !coalesced_o);

  a_r5_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (pend_cnt_o == '0 && pend_map_o == '0));

  a_r2_delivery_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_done_i && !clear_i && !eoi_valid_i && !sync_valid_i)
      |=> pend_map_o == $past(dlv_mask_i));

  a_r4_stray_eoi_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_valid_i && !pend_map_o[eoi_dest_i] && !dlv_done_i && !sync_valid_i && !clear_i)
      |=> $stable(pend_map_o));
endmodule

bind eoi_tracker eoi_tracker_chk #(.N_DEST(N_DEST), .IDX_W(IDX_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/eoi_tracker_tb_top.sv
module eoi_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int IW = 4;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clear, asrt, dlv, eoi_v, sync_v, sync_p;
  logic [N-1:0]  dlv_mask;
  logic [IW-1:0] eoi_d, sync_d;
  logic [N-1:0]  map_o;
  logic [CW-1:0] cnt_o;
  logic          busy_o, coal_o, err_s_o, err_u_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [N-1:0]  map;
    logic [CW-1:0] cnt;
    string         tag;
  } exp_t;
  exp_t exp_q[$];

  logic [N-1:0]  m_map;
  int            m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  eoi_tracker #(.N_DEST(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .assert_i(asrt),
    .dlv_done_i(dlv), .dlv_mask_i(dlv_mask),
    .eoi_valid_i(eoi_v), .eoi_dest_i(eoi_d),
    .sync_valid_i(sync_v), .sync_dest_i(sync_d), .sync_pend_i(sync_p),
    .pend_map_o(map_o), .pend_cnt_o(cnt_o), .busy_o(busy_o),
    .coalesced_o(coal_o), .err_start_o(err_s_o), .err_under_o(err_u_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares registered state one cycle after each op
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(map_o == e.map, {e.tag, " map"}, int'(map_o), int'(e.map));
        chk(cnt_o == e.cnt, {e.tag, " cnt"}, int'(cnt_o), int'(e.cnt));
      end
    end
  end

  task automatic idle_inputs();
    clear = 0; asrt = 0; dlv = 0; dlv_mask = '0;
    eoi_v = 0; eoi_d = '0; sync_v = 0; sync_d = '0; sync_p = 0;
  endtask

  // driver: one cycle of stimulus, model update, expected push
  task automatic op(input bit c, input bit a, input bit d, input logic [N-1:0] dm,
                    input bit ev, input int ed, input bit sv, input int sd, input bit sp,
                    input string tag);
    exp_t e;
    @(negedge clk);
    clear = c; asrt = a; dlv = d; dlv_mask = dm;
    eoi_v = ev; eoi_d = IW'(ed); sync_v = sv; sync_d = IW'(sd); sync_p = sp;
    #1;
    chk(coal_o == (a && m_cnt != 0), {tag, " R1 coalesced"}, int'(coal_o), int'(a && m_cnt != 0));
    chk(busy_o == (m_cnt != 0), {tag, " R9 busy"}, int'(busy_o), int'(m_cnt != 0));
    chk(err_s_o == (d && m_cnt != 0), {tag, " R3 err_start"}, int'(err_s_o), int'(d && m_cnt != 0));
    chk(err_u_o == 1'b0, {tag, " R7 err_under"}, int'(err_u_o), 0);
    // reference model, order: delivery, EOI, restore, clear
    if (d) begin
      m_map = dm;
      m_cnt = 0;
      for (int i = 0; i < N; i++) if (dm[i]) m_cnt++;
    end
    if (ev && m_map[ed]) begin m_map[ed] = 1'b0; m_cnt--; end
    if (sv) begin
      if (sp && !m_map[sd])      begin m_map[sd] = 1'b1; m_cnt++; end
      else if (!sp && m_map[sd]) begin m_map[sd] = 1'b0; m_cnt--; end
    end
    if (c) begin m_map = '0; m_cnt = 0; end
    @(posedge clk);
    e.map = m_map; e.cnt = CW'(m_cnt); e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    m_map = '0; m_cnt = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(map_o == '0 && cnt_o == '0, "R5 reset state", int'(cnt_o), 0);
    rst_n = 1;

    op(0,1,0,'0,0,0,0,0,0, "R1 idle assert");
    op(0,0,1,16'h0013,0,0,0,0,0, "R2 delivery 3 dests");
    op(0,1,0,'0,0,0,0,0,0, "R1 busy assert");
    op(0,0,0,'0,1,5,0,0,0, "R4 stray eoi");
    op(0,0,0,'0,1,1,0,0,0, "R4 eoi clears bit1");
    op(0,0,1,16'h0100,0,0,0,0,0, "R3 delivery while busy");
    op(0,0,0,'0,1,8,0,0,0, "R4 last eoi");
    op(0,0,1,16'h0006,1,2,0,0,0, "R8 delivery+eoi same cycle");
    op(0,0,0,'0,0,0,1,9,1, "R6 restore set");
    op(0,0,0,'0,0,0,1,9,1, "R6 restore set again");
    op(0,0,0,'0,0,0,1,2,0, "R6 restore clear");
    op(0,0,0,'0,0,0,1,3,0, "R6 restore clear unset");
    op(0,0,0,'0,1,9,1,9,1, "R8 eoi then restore same dest");
    op(1,1,1,16'h00FF,1,9,1,4,1, "R5 clear wins");
    op(0,0,1,16'hFFFF,0,0,0,0,0, "R9 all destinations");
    op(0,1,0,'0,1,15,0,0,0, "R9 eoi from full");
    drain();

    // asynchronous reset in mid-traffic
    @(negedge clk);
    rst_n = 0;
    #1;
    chk(map_o == '0 && cnt_o == '0, "R5 async reset", int'(cnt_o), 0);
    m_map = '0; m_cnt = 0;
    @(negedge clk);
    rst_n = 1;

    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] rm;
      rm = N'($urandom);
      op(($urandom % 40) == 0, 1'($urandom), ($urandom % 6) == 0, rm,
         1'($urandom), int'($urandom % N), ($urandom % 3) == 0, int'($urandom % N),
         1'($urandom), "R7 random mix");
    end
    drain();
    idle_inputs();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule